// File: doc/BRIEF.md
# Masked Parallel GPIO Output Bank

This block holds the output data values for a bank of general-purpose pads, arranged as ten ports of sixteen pins. The last port is only partly built, which gives 152 pins. One flat storage vector holds all of them. That vector drives the pad output bus directly, so every pin has a registered output.

Software reaches the storage through a simple register bus in two ways:

- **Per-pin words.** Each 32-bit word carries four pins, one byte lane per pin.
- **Port-wide masked words.** Each 32-bit word carries a 16-bit select mask and 16 bits of data for one whole port. Only the selected pins change. Pin 0 of the port sits at the top of each half.

Both paths are views onto the same bits, so a value written through one path is at once visible through the other. Read data is registered and returns one cycle after the address is presented.

Top module: `gpo_masked_bank`

## Requirements
- R1: Port word x sits at byte address 0x100 + 4x, for x from 0 to 9. Bit 31-y is the select bit for pin y of that port, and bit 15-y is its data bit. Pin y of port x is flat pin 16x + y on `pad_out`.
- R2: In a port-word write, a pin whose select bit is 1 takes its data bit, and a pin whose select bit is 0 keeps its value.
- R3: A port-word write with all sixteen select bits at 0 changes no pin.
- R4: Per-pin word k sits at byte address 4k, for k from 0 to 37, and covers pins 4k to 4k+3. Pin 4k+j uses byte lane j (bits 8j+7:8j). It is written only when `wr_be[j]` is 1, and it takes bit 8j of the write data.
- R5: A value written through either path is read back through the other, because both act on one storage vector.
- R6: A read of a port word returns 0 in bits 31:16 and the current pin values in bits 15:0, with the same bit order as R1. Every read returns its data on `rd_data` in the cycle after the address is presented.
- R7: A read of a per-pin word returns each pin's value in bit 0 of its lane. Bits 7:1 of every lane read as 0, and writes to those bits have no effect.
- R8: Port 9 has pins 0 to 7 only (flat pins 144 to 151). The select and data positions for its pins 8 to 15 are ignored on writes and read as 0.
- R9: Writes to addresses outside both regions change no pin, and reads of them return 0.
- R10: Synchronous reset clears every pin and `rd_data` to 0.
- R11: Byte strobes have no effect on port-word writes; the whole word always applies.
- R12: A write appears on `pad_out` right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 9 | Byte address of the word being accessed |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte strobes, used by per-pin writes |
| wr_en | input | 1 | Write enable |
| rd_data | output | 32 | Registered read data |
| pad_out | output | 152 | Pad output values, flat pin order |

## Verification
The assertions check four things on every cycle:

- Storage stays unchanged under unmapped writes, all-zero selects and empty strobe sets.
- Storage clears after reset.
- The select half of a port read is 0.
- The upper seven bits of every per-pin lane are 0.

The bench scenarios cover what needs a reference model:

- The reversed bit order between words and pins.
- Partial selects and partial strobes.
- A value crossing from one write path to the other.
- The truncated last port.
- The one-cycle read latency.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int DATA_W = 32;
  localparam int PORT_W = 16;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PIN  = 2'd1,
    ACC_PAR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpo_addr_decode.sv
module gpo_addr_decode
  import gpo_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int NUM_PINS = 152,
  parameter int NUM_PORTS = 10,
  parameter int PAR_BASE = 256
) (
  input  logic [ADDR_W-1:0]   addr,
  output acc_kind_e           kind,
  output logic [ADDR_W-3:0]   idx
);
  localparam int WORD_W        = ADDR_W - 2;
  localparam int NUM_PIN_WORDS = (NUM_PINS + LANES - 1) / LANES;
  localparam int PAR_WORD0     = PAR_BASE / 4;
  localparam logic [WORD_W-1:0] PIN_LIMIT = WORD_W'(NUM_PIN_WORDS);
  localparam logic [WORD_W-1:0] PAR_LO    = WORD_W'(PAR_WORD0);
  localparam logic [WORD_W-1:0] PAR_HI    = WORD_W'(PAR_WORD0 + NUM_PORTS);

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    kind = ACC_NONE;
    idx  = '0;
    if (word < PIN_LIMIT) begin
      kind = ACC_PIN;
      idx  = word;
    end else if (word >= PAR_LO && word < PAR_HI) begin
      kind = ACC_PAR;
      idx  = word - PAR_LO;
    end
  end
endmodule

// File: rtl/gpo_write_merge.sv
module gpo_write_merge
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 152,
  parameter int WORD_W   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  acc_kind_e           kind,
  input  logic [WORD_W-1:0]   idx,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [LANES-1:0]    be,
  output logic [NUM_PINS-1:0] store
);
  logic [NUM_PINS-1:0] next_bits;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int PORT = p / PORT_W;
    localparam int Y    = p % PORT_W;
    localparam int WRD  = p / LANES;
    localparam int LANE = p % LANES;
    logic par_hit;
    logic pin_hit;
    // per-pin path has priority if both ever select the same bit
    assign par_hit = we && (kind == ACC_PAR) && (idx == WORD_W'(PORT))
                     && wdata[DATA_W-1-Y];
    assign pin_hit = we && (kind == ACC_PIN) && (idx == WORD_W'(WRD)) && be[LANE];
    assign next_bits[p] = pin_hit ? wdata[LANE_W*LANE] :
                          par_hit ? wdata[PORT_W-1-Y]  : store[p];
  end

  always_ff @(posedge clk) begin
    if (rst) store <= '0;
    else     store <= next_bits;
  end

  // R9: writes outside both regions or reads leave storage untouched
  assert_unmapped_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(we && kind != ACC_NONE) |=> $stable(store));
  // R3: an empty select half changes nothing
  assert_mask_zero_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (we && kind == ACC_PAR && wdata[DATA_W-1:PORT_W] == '0) |=> $stable(store));
  // R4: a per-pin write with no strobes changes nothing
  assert_no_strobe_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (we && kind == ACC_PIN && be == '0) |=> $stable(store));
  // R10: reset clears storage
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (store == '0));
endmodule

// File: rtl/gpo_readback.sv
module gpo_readback
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 152,
  parameter int WORD_W   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  acc_kind_e           kind,
  input  logic [WORD_W-1:0]   idx,
  input  logic [NUM_PINS-1:0] store,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (kind == ACC_PIN && idx == WORD_W'(p / LANES))
        rd_next[LANE_W*(p % LANES)] = store[p];
      if (kind == ACC_PAR && idx == WORD_W'(p / PORT_W))
        rd_next[PORT_W-1-(p % PORT_W)] = store[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R6: select half of a port word always reads as zero
  assert_mask_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(kind) == ACC_PAR) |-> (rdata[DATA_W-1:PORT_W] == '0));
  // R7: only bit 0 of each lane can be set on a per-pin read
  assert_lane_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(kind) == ACC_PIN) |-> ((rdata & 32'hFEFE_FEFE) == '0));
  // R9: unmapped reads return zero
  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(kind) == ACC_NONE) |-> (rdata == '0));
endmodule

// File: rtl/gpo_masked_bank.sv
module gpo_masked_bank
  import gpo_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int NUM_PORTS = 10,
  parameter int NUM_PINS  = 152,
  parameter int PAR_BASE  = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wr_data,
  input  logic [3:0]          wr_be,
  input  logic                wr_en,
  output logic [31:0]         rd_data,
  output logic [NUM_PINS-1:0] pad_out
);
  localparam int WORD_W = ADDR_W - 2;

  acc_kind_e          kind;
  logic [WORD_W-1:0]  idx;
  logic [NUM_PINS-1:0] store;

  gpo_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .NUM_PORTS(NUM_PORTS), .PAR_BASE(PAR_BASE)
  ) u_decode (
    .addr(addr), .kind(kind), .idx(idx)
  );

  gpo_write_merge #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_merge (
    .clk(clk), .rst(rst), .kind(kind), .idx(idx), .we(wr_en),
    .wdata(wr_data), .be(wr_be), .store(store)
  );

  gpo_readback #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_read (
    .clk(clk), .rst(rst), .kind(kind), .idx(idx), .store(store), .rdata(rd_data)
  );

  assign pad_out = store;
endmodule

// File: tb/gpo_masked_bank_bench.sv
module gpo_masked_bank_bench;
  localparam int NP = 152;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [8:0]    addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_out;

  gpo_masked_bank u_gpo_masked_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_en(wr_en), .rd_data(rd_data), .pad_out(pad_out)
  );

  logic [NP-1:0] model = '0;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] q_val[$];
  string       q_tag[$];
  logic rd_issue = 1'b0;
  logic rd_flag_d = 1'b0;

  always @(posedge clk) rd_flag_d <= rd_issue;

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rd_flag_d && q_val.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s rd_data act=%h exp=%h", t, rd_data, e);
      end
    end
  end

  function automatic logic [31:0] par_word(logic [15:0] sel, logic [15:0] dat);
    logic [31:0] w = '0;
    for (int y = 0; y < 16; y++) begin
      w[31-y] = sel[y];
      w[15-y] = dat[y];
    end
    return w;
  endfunction

  function automatic logic [31:0] expect_read(logic [8:0] a);
    logic [31:0] w = '0;
    int k = int'(a) / 4;
    if (k < 38) begin
      for (int j = 0; j < 4; j++) w[8*j] = model[4*k+j];
    end else if (k >= 64 && k < 74) begin
      for (int y = 0; y < 16; y++)
        if (16*(k-64)+y < NP) w[15-y] = model[16*(k-64)+y];
    end
    return w;
  endfunction

  task automatic bus_write(logic [8:0] a, logic [31:0] d, logic [3:0] b);
    int k = int'(a) / 4;
    @(negedge clk);
    addr = a; wr_data = d; wr_be = b; wr_en = 1'b1;
    if (k < 38) begin
      for (int j = 0; j < 4; j++) if (b[j]) model[4*k+j] = d[8*j];
    end else if (k >= 64 && k < 74) begin
      for (int y = 0; y < 16; y++)
        if (16*(k-64)+y < NP && d[31-y]) model[16*(k-64)+y] = d[15-y];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [8:0] a, string tag);
    @(negedge clk);
    addr = a; wr_en = 1'b0; rd_issue = 1'b1;
    q_val.push_back(expect_read(a));
    q_tag.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic check_pads(string tag);
    n_chk++;
    if (pad_out !== model) begin
      n_fail++;
      $display("FAIL %s pad_out act=%h exp=%h", tag, pad_out, model);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    check_pads("R10 reset pins");
    n_chk++;
    if (rd_data !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 reset rd_data act=%h exp=%h", rd_data, 32'h0);
    end

    // R1 R2 R12: full port write, reversed bit order
    bus_write(9'h100, par_word(16'hFFFF, 16'hA5C3), 4'hF);
    check_pads("R1 R12 port0 full write");
    bus_read(9'h100, "R6 port0 readback");
    // R2: partial select on port 2
    bus_write(9'h108, par_word(16'h00F0, 16'hFFFF), 4'hF);
    check_pads("R2 partial select");
    bus_write(9'h100, par_word(16'h0F0F, 16'h0000), 4'hF);
    check_pads("R2 partial clear");
    // R3: empty select
    bus_write(9'h104, par_word(16'h0000, 16'hFFFF), 4'hF);
    check_pads("R3 empty select");
    // R4 R7: per-pin lanes, upper bits and missing strobe
    bus_write(9'h000, 32'hFF_FE_03_01, 4'b0111);
    check_pads("R4 R7 per-pin lanes");
    bus_read(9'h000, "R7 per-pin readback");
    bus_write(9'h004, 32'h01_01_01_01, 4'b0000);
    check_pads("R4 no strobes");
    // R5: coherence both ways
    bus_write(9'h024, 32'h00_01_00_00, 4'hF);
    bus_read(9'h108, "R5 per-pin then port read");
    bus_write(9'h10C, par_word(16'hFFFF, 16'h8421), 4'hF);
    bus_read(9'h030, "R5 port then per-pin read");
    bus_read(9'h03C, "R5 port then per-pin read hi");
    // R8: truncated last port
    bus_write(9'h124, par_word(16'hFFFF, 16'hFFFF), 4'hF);
    check_pads("R8 last port write");
    bus_read(9'h124, "R8 last port read");
    bus_read(9'h094, "R8 last per-pin word");
    // R9: unmapped addresses
    bus_write(9'h0A0, 32'hFFFF_FFFF, 4'hF);
    bus_write(9'h1F0, 32'hFFFF_FFFF, 4'hF);
    check_pads("R9 unmapped writes");
    bus_read(9'h0A0, "R9 unmapped read low");
    bus_read(9'h1F0, "R9 unmapped read high");
    // R11: strobes ignored on port words
    bus_write(9'h110, par_word(16'hFFFF, 16'h1234), 4'h0);
    check_pads("R11 port write without strobes");
    bus_read(9'h110, "R11 port4 readback");
    // R10: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = '0;
    check_pads("R10 reset after traffic");
    bus_read(9'h10C, "R10 read after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule